// File: doc/BRIEF.md
# Stuck-At Fault Test Sequencer

This block is a small self-checking test engine wrapped around a three-input AND circuit. The circuit under test has an internal node D, which is the AND of inputs A and B. Its output E is the AND of D and C. None of its intermediate nodes can be seen from outside. Any one of the five nodes can be forced to a stuck value through the fault-injection inputs. This shows whether a chosen set of test vectors exposes that fault at E.

A start pulse launches one run. The engine first clears its result state. It then drives one vector per clock into the circuit and into a fault-free model, and registers each comparison one cycle later. When the run finishes, it raises a one-cycle done pulse. Beside the pulse it holds three results: a fail flag, the index of the first vector that mismatched, and the number of vectors compared.

A mode input selects the run type. The compact run uses four path-sensitised vectors, which still expose every single stuck-at fault. The exhaustive run uses all eight input combinations.

Top module: `stuck_fault_tester`

## Requirements
- R1: After reset, busy, done and fail are 0, first_fail_idx is 0 and vec_count is 0.
- R2: With exhaustive=0 sampled at start, vectors ABC (A is bit 2, C is bit 0) are applied in the order 111, 011, 101, 110, at indices 0 to 3. At done, vec_count is 4, and done is high in the cycle after the 6th rising edge that follows the edge accepting start.
- R3: With exhaustive=1 sampled at start, vectors 000 to 111 are applied in ascending order, with the index equal to the vector value. At done, vec_count is 8, and done arrives after the 10th rising edge following acceptance.
- R4: Fault selection uses three inputs. flt_node picks the node: 0=A, 1=B, 2=C, 3=D, 4=E. flt_val is the stuck value, and flt_en enables the fault. When flt_en is 0, or when flt_node is 5 to 7, the circuit is fault-free and fail stays 0.
- R5: fail is set when the faulty output differs from the fault-free output for at least one applied vector. It then stays set for the rest of the run, and first_fail_idx holds the lowest mismatching index.
- R6: The compact run sets fail for every one of the ten single stuck-at faults.
- R7: In an exhaustive run, D stuck-at-1 reports first_fail_idx 1 (ABC=001, where the expected E is 0 and the faulty E is 1). In a compact run, the same fault reports first_fail_idx 1 (ABC=011).
- R8: A start that arrives while busy is 1 is ignored: the run keeps its mode, its timing and its results.
- R9: done is a one-cycle pulse. busy is 1 from the cycle after acceptance until done, and busy is 0 while done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, accepted only when idle |
| exhaustive | input | 1 | 1 selects all eight vectors, 0 the compact four |
| flt_en | input | 1 | Enables fault injection |
| flt_node | input | 3 | Faulted node: 0=A 1=B 2=C 3=D 4=E |
| flt_val | input | 1 | Stuck value forced on the selected node |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | A mismatch was seen in the last run |
| first_fail_idx | output | 3 | Index of the first mismatching vector |
| vec_count | output | 4 | Number of vectors compared in the last run |

## Verification
The bench targets these corner cases:

- Faults that only one compact vector exposes, such as A, B or C stuck at 0. A design with the wrong vector order, or with a vector missing, would report the wrong first index or no fail at all.
- D stuck-at-1 in both modes. An engine that starts its index at 1, or that drops the first comparison, would report index 0 or 2.
- A second start sent in mid-run with the mode flipped. A design that restarts would shift done or change the count.
- A clean run that follows a failing run. A fail flag that is not cleared at start would show up here.

// File: rtl/stuck_fault_tester.sv
module stuck_fault_tester #(
  parameter int NODES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       exhaustive,
  input  logic       flt_en,
  input  logic [2:0] flt_node,
  input  logic       flt_val,
  output logic       busy,
  output logic       done,
  output logic       fail,
  output logic [2:0] first_fail_idx,
  output logic [3:0] vec_count
);
  typedef enum logic [1:0] {S_IDLE, S_INIT, S_APPLY, S_DRAIN} st_t;
  st_t st;
  logic       mode_q;
  logic [2:0] idx, abc;
  logic       p_valid, p_mis;
  logic [2:0] p_idx;

  always_comb begin
    if (mode_q) abc = idx;
    else case (idx[1:0])
      2'd0:    abc = 3'b111;
      2'd1:    abc = 3'b011;
      2'd2:    abc = 3'b101;
      default: abc = 3'b110;
    endcase
  end

  function automatic logic hit(input logic [2:0] n);
    return flt_en && flt_node == n && int'(n) < NODES;
  endfunction

  logic na, nb, nc, nd, ne, good;
  assign na   = hit(3'd0) ? flt_val : abc[2];
  assign nb   = hit(3'd1) ? flt_val : abc[1];
  assign nc   = hit(3'd2) ? flt_val : abc[0];
  assign nd   = hit(3'd3) ? flt_val : (na & nb);
  assign ne   = hit(3'd4) ? flt_val : (nd & nc);
  assign good = &abc;
  assign busy = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_q <= 1'b0; idx <= '0;
      p_valid <= 1'b0; p_mis <= 1'b0; p_idx <= '0;
      done <= 1'b0; fail <= 1'b0; first_fail_idx <= '0; vec_count <= '0;
    end else begin
      done    <= 1'b0;
      p_valid <= 1'b0;
      if (p_valid) begin
        vec_count <= vec_count + 4'd1;
        if (p_mis && !fail) begin
          fail <= 1'b1;
          first_fail_idx <= p_idx;
        end
      end
      case (st)
        S_IDLE: if (start) begin
          st <= S_INIT;
          mode_q <= exhaustive;
        end
        S_INIT: begin
          st <= S_APPLY; idx <= '0;
          fail <= 1'b0; first_fail_idx <= '0; vec_count <= '0;
        end
        S_APPLY: begin
          p_valid <= 1'b1;
          p_mis   <= ne != good;
          p_idx   <= idx;
          idx     <= idx + 3'd1;
          if (idx == (mode_q ? 3'd7 : 3'd3)) st <= S_DRAIN;
        end
        default: begin
          st <= S_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_done_idle:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r2_count_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vec_count == (mode_q ? 4'd8 : 4'd4));
  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail && st != S_INIT |=> fail);
  a_r5_first_stable: assert property (@(posedge clk) disable iff (!rst_n)
    fail && st != S_INIT |=> $stable(first_fail_idx));
  a_r4_clean_compare: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_APPLY && !flt_en |=> !p_mis);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_APPLY && start |=> st != S_INIT && $stable(mode_q));
endmodule

// File: tb/stuck_fault_tester_test.sv
module stuck_fault_tester_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, start = 0, exhaustive = 0, flt_en = 0, flt_val = 0;
  logic [2:0] flt_node = 0;
  logic busy, done, fail;
  logic [2:0] first_fail_idx;
  logic [3:0] vec_count;
  int tests = 0, fails = 0, cycles = 0;

  stuck_fault_tester uut (.clk, .rst_n, .start, .exhaustive, .flt_en, .flt_node,
    .flt_val, .busy, .done, .fail, .first_fail_idx, .vec_count);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [2:0] vec(input logic m, input int i);
    logic [2:0] c [4] = '{3'b111, 3'b011, 3'b101, 3'b110};
    return m ? 3'(i) : c[i];
  endfunction

  function automatic logic eval(input logic [2:0] v, input logic en, input logic [2:0] n, input logic sv);
    logic a, b, c, d, e;
    a = (en && n == 0) ? sv : v[2];
    b = (en && n == 1) ? sv : v[1];
    c = (en && n == 2) ? sv : v[0];
    d = (en && n == 3) ? sv : a & b;
    e = (en && n == 4) ? sv : d & c;
    return e;
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic run(input logic m, input logic en, input logic [2:0] n, input logic sv,
                     input bit extra, input string tag);
    int cyc = 0, n_vec = m ? 8 : 4, e_first = 0;
    bit e_fail = 0, busy_ok = 1;
    for (int i = 0; i < n_vec; i++)
      if (!e_fail && eval(vec(m, i), en, n, sv) != (&vec(m, i))) begin
        e_fail = 1; e_first = i;
      end
    @(negedge clk);
    exhaustive = m; flt_en = en; flt_node = n; flt_val = sv; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && cyc < 50) begin
      if (!busy) busy_ok = 0;
      start = extra && cyc == 2;
      if (extra && cyc == 2) exhaustive = !m;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    chk({tag, " R9 busy through run"}, busy_ok, 1);
    chk({tag, " R9 busy low at done"}, busy, 0);
    chk({tag, m ? " R3 latency" : " R2 latency"}, cyc, m ? 10 : 6);
    chk({tag, m ? " R3 count" : " R2 count"}, vec_count, n_vec);
    chk({tag, " R5 fail"}, fail, e_fail);
    if (e_fail) chk({tag, " R5 first index"}, first_fail_idx, e_first);
    @(negedge clk);
    chk({tag, " R9 done pulse"}, done, 0);
  endtask

  initial begin
    process::self().srandom(32'h5eed);
    #(3*CLK_PERIOD/2);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 fail", fail, 0);
    chk("R1 idx", first_fail_idx, 0); chk("R1 count", vec_count, 0);
    rst_n = 1;
    run(0, 0, 0, 0, 0, "R2 clean compact");
    run(1, 0, 0, 0, 0, "R3 clean exhaustive");
    run(1, 0, 3, 1, 0, "R4 enable low");
    run(0, 1, 6, 1, 0, "R4 code 6");
    for (int nd = 0; nd < 5; nd++)
      for (int v = 0; v < 2; v++) begin
        run(0, 1, 3'(nd), 1'(v), 0, "R6 compact fault");
        chk("R6 detected", fail, 1);
      end
    run(1, 1, 3, 1, 0, "R7 D sa1 exhaustive");
    chk("R7 exhaustive index", first_fail_idx, 1);
    run(0, 1, 3, 1, 0, "R7 D sa1 compact");
    chk("R7 compact index", first_fail_idx, 1);
    run(0, 1, 0, 0, 1, "R8 start during compact");
    run(1, 1, 4, 1, 1, "R8 start during exhaustive");
    run(0, 0, 0, 0, 0, "R5 cleared after fail");
    for (int k = 0; k < 60; k++)
      run(1'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom % 4 == 0), "random");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule